// File: doc/BRIEF.md
# SIR Receive Frame Unwrapper

This block sits behind the byte assembler of a slow-rate infrared receiver. It takes the raw received byte stream and delivers only the frame contents. It hunts for the opening flag and discards everything that comes before it, including repeated opening flags. It strips the opening and closing flags and undoes the transparency escaping. The 16-bit frame check sequence stays at the tail of each packet; checking it is the job of a later stage.

Each output byte carries a first-of-packet flag. The final byte is held back until the closing flag arrives, so that the end-of-packet flag can be set on it. A programmable length limit protects the buffer downstream. A frame that runs past the limit is cut short and flagged, and its remainder is thrown away. Two mode bits decide whether the filter is active. When it is inactive, bytes pass straight through unchanged.

Top module: `sir_rx_unwrap`

## Requirements
- R1: `delim_flags` always reads 16'hC1C0: the opening flag 0xC0 in bits [7:0] and the closing flag 0xC1 in bits [15:8].
- R2: Bytes received outside a frame are dropped. So are repeated 0xC0 bytes before the first payload byte. The first payload byte of a frame is output with `out_first`=1.
- R3: A 0x7D byte is dropped, and the byte that follows it is output XORed with 0x20.
- R4: Every payload byte between the flags is output in order, including the two trailing FCS bytes. When 0xC1 arrives, the last byte is output with `out_last`=1 and `out_err`=0.
- R5: A 0x7D followed directly by 0xC1 aborts the frame. The last byte already received is output with `out_last`=1 and `out_err`=1.
- R6: A 0xC0 after payload has started ends the partial frame. Its last byte is output with `out_last`=1 and `out_err`=1, and a new frame begins.
- R7: A frame may hold at most `max_len` payload bytes. Any further payload byte makes the `max_len`-th byte come out with `out_last`=1 and `out_err`=1, and all bytes up to the next 0xC1 are then dropped. A frame of exactly `max_len` bytes ends normally.
- R8: A frame that has no payload produces no output.
- R9: The filter is active only when `filt_en`=1 and either `sir_mode`=1 or `filt_test`=1. Otherwise every accepted byte is output unchanged, with all three flags at 0.
- R10: `frame_len` gives the number of payload bytes accepted in the current frame. It returns to 0 after 0xC1.
- R11: While `out_valid`=1 and `out_ready`=0, the output byte and its flags hold steady, and no byte is lost.
- R12: After reset, `out_valid`=0 and `frame_len`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| filt_en | input | 1 | Filter enable |
| sir_mode | input | 1 | Receiver is in slow-rate mode |
| filt_test | input | 1 | Allow the filter outside slow-rate mode |
| max_len | input | 12 | Maximum payload bytes per frame |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted |
| in_data | input | 8 | Received byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts the output byte |
| out_data | output | 8 | Payload byte |
| out_first | output | 1 | First byte of a packet |
| out_last | output | 1 | Last byte of a packet |
| out_err | output | 1 | Packet ended abnormally |
| frame_len | output | 12 | Payload bytes in the current frame |
| delim_flags | output | 16 | Flag read-back: closing flag in [15:8], opening flag in [7:0] |

## Verification
The bench builds the block with its default 12-bit length field. It changes `max_len` at run time to small values such as 3. This makes truncation and the exact-limit case reachable in a few bytes, while normal frames run under a limit of 20. A sink that is ready on only two cycles out of three, plus a long forced stall, exercises the hold-back of the final byte against backpressure.

// File: rtl/sir_unwrap_pkg.sv
package sir_unwrap_pkg;
  localparam logic [7:0] SIR_BOF = 8'hC0;
  localparam logic [7:0] SIR_EOF = 8'hC1;
  localparam logic [7:0] SIR_ESC = 8'h7D;
  localparam logic [7:0] SIR_XOR = 8'h20;

  typedef enum logic [1:0] {ST_HUNT, ST_BODY, ST_ESC, ST_DROP} unwrap_st_e;
  typedef enum logic [1:0] {K_DATA, K_BOF, K_EOF, K_ESC} byte_kind_e;
endpackage

// File: rtl/sir_byte_class.sv
module sir_byte_class
  import sir_unwrap_pkg::*;
(
  input  logic [7:0] byte_i,
  output byte_kind_e kind_o
);
  always_comb begin
    unique case (byte_i)
      SIR_BOF: kind_o = K_BOF;
      SIR_EOF: kind_o = K_EOF;
      SIR_ESC: kind_o = K_ESC;
      default: kind_o = K_DATA;
    endcase
  end
endmodule

// File: rtl/sir_len_guard.sv
module sir_len_guard #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic [LEN_W-1:0] limit,
  output logic [LEN_W-1:0] count,
  output logic             at_limit
);
  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc)   count <= count + 1'b1;
  end

  assign at_limit = (count >= limit);
endmodule

// File: rtl/sir_rx_unwrap.sv
module sir_rx_unwrap
  import sir_unwrap_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             filt_en,
  input  logic             sir_mode,
  input  logic             filt_test,
  input  logic [LEN_W-1:0] max_len,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_first,
  output logic             out_last,
  output logic             out_err,
  output logic [LEN_W-1:0] frame_len,
  output logic [15:0]      delim_flags
);
  unwrap_st_e st, st_nx;
  byte_kind_e kind;
  logic       active, accept;
  logic       held_v, held_first;
  logic [7:0] held_d;
  logic       len_clr, len_inc, at_limit;
  logic       hold_load, hold_clr;
  logic [7:0] take_d;
  logic       take, close, close_err, restart;
  logic       emit, e_first, e_last, e_err;
  logic [7:0] e_data;

  assign delim_flags = {SIR_EOF, SIR_BOF};
  assign active      = filt_en && (sir_mode || filt_test);
  assign in_ready    = !out_valid || out_ready;
  assign accept      = in_valid && in_ready;

  sir_byte_class u_class (.byte_i(in_data), .kind_o(kind));

  sir_len_guard #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst(rst), .clr(len_clr), .inc(len_inc),
    .limit(max_len), .count(frame_len), .at_limit(at_limit)
  );

  // Decode one accepted byte into frame actions.
  always_comb begin
    st_nx = st; take = 1'b0; take_d = in_data;
    close = 1'b0; close_err = 1'b0; restart = 1'b0;
    if (accept && active) begin
      unique case (st)
        ST_HUNT: if (kind == K_BOF) restart = 1'b1;
        ST_BODY: begin
          unique case (kind)
            K_BOF:  begin restart = 1'b1; close = 1'b1; close_err = 1'b1; end
            K_EOF:  begin close = 1'b1; st_nx = ST_HUNT; end
            K_ESC:  st_nx = ST_ESC;
            default: take = 1'b1;
          endcase
        end
        ST_ESC: begin
          unique case (kind)
            K_BOF:  begin restart = 1'b1; close = 1'b1; close_err = 1'b1; end
            K_EOF:  begin close = 1'b1; close_err = 1'b1; st_nx = ST_HUNT; end
            default: begin take = 1'b1; take_d = in_data ^ SIR_XOR; end
          endcase
        end
        default: begin
          if (kind == K_BOF)      restart = 1'b1;
          else if (kind == K_EOF) st_nx = ST_HUNT;
        end
      endcase
      if (restart) st_nx = ST_BODY;
    end
  end

  // Turn frame actions into an output beat and bookkeeping.
  always_comb begin
    emit = 1'b0; e_data = held_d; e_first = held_first; e_last = 1'b0; e_err = 1'b0;
    hold_load = 1'b0; hold_clr = 1'b0; len_clr = 1'b0; len_inc = 1'b0;
    if (accept && !active) begin
      emit = 1'b1; e_data = in_data; e_first = 1'b0;
      hold_clr = 1'b1; len_clr = 1'b1;
    end else begin
      if (close) begin
        emit = held_v; e_last = 1'b1; e_err = close_err;
        hold_clr = 1'b1; len_clr = 1'b1;
      end
      if (restart) begin
        hold_clr = 1'b1; len_clr = 1'b1;
      end
      if (st == ST_DROP && st_nx == ST_HUNT) len_clr = 1'b1;
      if (take) begin
        if (at_limit) begin
          emit = held_v; e_last = 1'b1; e_err = 1'b1; hold_clr = 1'b1;
        end else begin
          emit = held_v; hold_load = 1'b1; len_inc = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_HUNT;
      held_v <= 1'b0; held_first <= 1'b0; held_d <= '0;
      out_valid <= 1'b0; out_data <= '0;
      out_first <= 1'b0; out_last <= 1'b0; out_err <= 1'b0;
    end else begin
      if (accept && !active)            st <= ST_HUNT;
      else if (take && at_limit)        st <= ST_DROP;
      else if (take)                    st <= ST_BODY;
      else                              st <= st_nx;

      if (hold_load) begin
        held_v <= 1'b1; held_first <= !held_v; held_d <= take_d;
      end else if (hold_clr) begin
        held_v <= 1'b0;
      end

      if (emit) begin
        out_valid <= 1'b1; out_data <= e_data;
        out_first <= e_first; out_last <= e_last; out_err <= e_err;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sir_rx_unwrap_chk.sv
module sir_rx_unwrap_chk #(
  parameter int LEN_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             filt_en,
  input logic             sir_mode,
  input logic             filt_test,
  input logic [LEN_W-1:0] max_len,
  input logic             in_valid,
  input logic             in_ready,
  input logic [7:0]       in_data,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_first,
  input logic             out_last,
  input logic             out_err,
  input logic [LEN_W-1:0] frame_len
);
  // R5 R6 R7: an error beat always closes its packet
  assert_err_implies_last_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> out_last);

  // R11: a stalled beat holds its contents
  assert_hold_when_stalled_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_first)
                                   && $stable(out_last) && $stable(out_err)));

  // R7 R10: the length counter steps by one and stays within the limit
  assert_len_bounded_R7: assert property (@(posedge clk) disable iff (rst)
    (frame_len > $past(frame_len)) |-> ((frame_len <= max_len)
                                        && (frame_len == $past(frame_len) + 1'b1)));

  // R9: inactive filter forwards bytes unchanged with flags low
  assert_passthrough_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !(filt_en && (sir_mode || filt_test)))
    |=> (out_valid && out_data == $past(in_data) && !out_first && !out_last && !out_err));
endmodule

bind sir_rx_unwrap sir_rx_unwrap_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .filt_en(filt_en), .sir_mode(sir_mode), .filt_test(filt_test),
  .max_len(max_len), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_first(out_first), .out_last(out_last), .out_err(out_err), .frame_len(frame_len)
);

// File: tb/sir_rx_unwrap_bench.sv
module sir_rx_unwrap_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic filt_en = 1'b1, sir_mode = 1'b1, filt_test = 1'b0;
  logic [LEN_W-1:0] max_len = 12'd20;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_data = '0;
  logic out_valid, out_ready = 1'b1;
  logic [7:0] out_data;
  logic out_first, out_last, out_err;
  logic [LEN_W-1:0] frame_len;
  logic [15:0] delim_flags;

  int n_chk = 0, n_fail = 0, cyc = 0, ready_mode = 0;
  logic [10:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sir_rx_unwrap #(.LEN_W(LEN_W)) u_sir_rx_unwrap (
    .clk(clk), .rst(rst), .filt_en(filt_en), .sir_mode(sir_mode), .filt_test(filt_test),
    .max_len(max_len), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_first(out_first), .out_last(out_last), .out_err(out_err),
    .frame_len(frame_len), .delim_flags(delim_flags)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_beat(input logic [7:0] d, input bit f, input bit l, input bit e,
                             input string tag);
    exp_q.push_back({e, l, f, d});
    tag_q.push_back(tag);
  endtask

  task automatic send(input logic [7:0] b);
    in_valid = 1'b1; in_data = b;
    forever begin
      if (in_ready) begin
        @(negedge clk); #1;
        break;
      end
      @(negedge clk); #1;
    end
    in_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    repeat (8) @(negedge clk);
    #1;
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  // Scoreboard monitor: a beat seen valid and ready here transfers at the next edge.
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? (cyc % 3 != 0) : 1'b0;
      #1;
      if (!rst && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "unexpected beat", {out_err, out_last, out_first, out_data}, 0);
        end else begin
          logic [10:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({out_err, out_last, out_first, out_data} == e, t,
                {out_err, out_last, out_first, out_data}, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R12 reset valid", out_valid, 0);
    check(frame_len == 0, "R12 reset len", frame_len, 0);
    check(delim_flags == 16'hC1C0, "R1 delimiters", delim_flags, 16'hC1C0);
    rst = 1'b0;
    @(negedge clk); #1;

    // R2 R4 R10: junk, extra openers, payload with FCS
    expect_beat(8'hA1, 1, 0, 0, "R2 first");
    expect_beat(8'hA2, 0, 0, 0, "R4 mid");
    expect_beat(8'hA3, 0, 0, 0, "R4 mid");
    expect_beat(8'hF1, 0, 0, 0, "R4 fcs1");
    expect_beat(8'hF2, 0, 1, 0, "R4 fcs2 last");
    send(8'h55); send(8'h11); send(8'hC0); send(8'hC0); send(8'hC0);
    send(8'hA1); send(8'hA2); send(8'hA3); send(8'hF1); send(8'hF2);
    check(frame_len == 5, "R10 count", frame_len, 5);
    send(8'hC1);
    check(frame_len == 0, "R10 cleared", frame_len, 0);
    drain("R4 drain");

    // R3: escapes
    expect_beat(8'h7D, 1, 0, 0, "R3 esc 5D");
    expect_beat(8'h7E, 0, 0, 0, "R3 esc 5E");
    expect_beat(8'hC0, 0, 0, 0, "R3 esc E0");
    expect_beat(8'h33, 0, 1, 0, "R3 last");
    send(8'hC0); send(8'h7D); send(8'h5D); send(8'h7D); send(8'h5E);
    send(8'h7D); send(8'hE0); send(8'h33); send(8'hC1);
    drain("R3 drain");

    // R5: abort by escape then closer, stray byte afterwards dropped
    expect_beat(8'h01, 1, 0, 0, "R5 first");
    expect_beat(8'h02, 0, 1, 1, "R5 abort");
    send(8'hC0); send(8'h01); send(8'h02); send(8'h7D); send(8'hC1); send(8'h44);
    drain("R5 drain");

    // R6: opener mid-frame
    expect_beat(8'h10, 1, 0, 0, "R6 first");
    expect_beat(8'h20, 0, 1, 1, "R6 partial err");
    expect_beat(8'h30, 1, 0, 0, "R6 new first");
    expect_beat(8'h40, 0, 1, 0, "R6 new last");
    send(8'hC0); send(8'h10); send(8'h20); send(8'hC0);
    send(8'h30); send(8'h40); send(8'hC1);
    drain("R6 drain");

    // R7: truncation and exact limit
    max_len = 12'd3;
    expect_beat(8'h01, 1, 0, 0, "R7 first");
    expect_beat(8'h02, 0, 0, 0, "R7 mid");
    expect_beat(8'h03, 0, 1, 1, "R7 truncated");
    send(8'hC0); send(8'h01); send(8'h02); send(8'h03); send(8'h04); send(8'h05);
    send(8'hC1);
    check(frame_len == 0, "R7 len after drop", frame_len, 0);
    expect_beat(8'h07, 1, 0, 0, "R7 exact first");
    expect_beat(8'h08, 0, 0, 0, "R7 exact mid");
    expect_beat(8'h09, 0, 1, 0, "R7 exact last");
    send(8'hC0); send(8'h07); send(8'h08); send(8'h09); send(8'hC1);
    drain("R7 drain");
    max_len = 12'd20;

    // R8: empty frames
    send(8'hC0); send(8'hC1); send(8'hC0); send(8'hC0); send(8'hC1);
    drain("R8 empty");

    // R9: inactive filter passes through; test bit enables it
    sir_mode = 1'b0;
    expect_beat(8'hC0, 0, 0, 0, "R9 pass C0");
    expect_beat(8'h7D, 0, 0, 0, "R9 pass 7D");
    expect_beat(8'h12, 0, 0, 0, "R9 pass 12");
    send(8'hC0); send(8'h7D); send(8'h12);
    drain("R9 pass drain");
    filt_test = 1'b1;
    expect_beat(8'h66, 1, 1, 0, "R9 test mode");
    send(8'hC0); send(8'h66); send(8'hC1);
    drain("R9 test drain");
    filt_test = 1'b0; sir_mode = 1'b1; filt_en = 1'b0;
    expect_beat(8'hC1, 0, 0, 0, "R9 disabled");
    send(8'hC1);
    drain("R9 disabled drain");
    filt_en = 1'b1;

    // R11: sink ready two cycles in three
    ready_mode = 1;
    expect_beat(8'hB1, 1, 0, 0, "R11 first");
    expect_beat(8'hB2, 0, 0, 0, "R11 mid");
    expect_beat(8'hB3, 0, 0, 0, "R11 mid");
    expect_beat(8'hB4, 0, 1, 0, "R11 last");
    send(8'hC0); send(8'hB1); send(8'hB2); send(8'hB3); send(8'hB4); send(8'hC1);
    drain("R11 pattern drain");

    // R11: long stall holds the beat
    ready_mode = 2;
    expect_beat(8'hAA, 1, 0, 0, "R11 stall first");
    expect_beat(8'hBB, 0, 1, 0, "R11 stall last");
    fork
      begin
        send(8'hC0); send(8'hAA); send(8'hBB); send(8'hC1);
      end
    join_none
    repeat (12) @(negedge clk);
    #2;
    check(out_valid && out_data == 8'hAA, "R11 held", out_data, 8'hAA);
    ready_mode = 0;
    wait fork;
    drain("R11 stall drain");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule